// File: doc/BRIEF.md
# Slot-Table Bus Arbiter

This block decides which of several bus masters owns a shared bus. Software loads a table of sixteen ordered time slots. Each slot either names one master or is switched off. The arbiter walks the table in a fixed order. At each arbitration point it hands the bus to the owner of the next live slot whose master is asking for it. A master that appears in several slots gets a matching share of the bus. The usual setup places the CPU, master 0, in every second slot, which gives it half of the grants.

The table sits in four 32-bit registers behind a plain write port. Each register holds four 8-bit slot fields. Requests come in as one bit per master. Each master also has a transfer-end strobe. A grant is registered and stays with its master until that master drops its request or raises its end strobe. The same cycle is then an arbitration point. When every slot is switched off, the arbiter falls back to serving master 0 alone.

Top module: `slot_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, no grant is given. The slot pointer starts at slot 0, and all sixteen slot fields reset to zero, which means switched off.
- R2: In a slot field, bit 7 switches the slot on and bits [2:0] give the master ID. Bits [6:3] are ignored. An ID of NUM_MASTERS or above can never be granted.
- R3: The visiting order is register 0 bits [31:24] (slot 0), then [23:16], [15:8] and [7:0], then register 1 in the same pattern, and so on up to slot 15. After slot 15 the walk wraps to slot 0. Register n is written with cfg_addr = n.
- R4: At an arbitration point the grant goes to the first live slot, counting from the pointer, whose master is requesting. Slots whose owner is idle are skipped without an idle bus cycle. The pointer then moves to the slot after the one granted.
- R5: A slot that is switched off is never granted, even when the master named in its field is requesting.
- R6: A master that owns k of the live slots receives k grants per walk of the table while all masters keep requesting. With the CPU in every second live slot, the CPU receives half of all grants.
- R7: A grant is held while its master keeps requesting and its xfer_done bit stays low. It is released in the cycle where either condition fails, and that cycle is an arbitration point.
- R8: The grant vector is one-hot or zero, grant_id names the granted master, and a grant only goes to a master that was requesting in the cycle before it appeared.
- R9: If every slot is switched off, master 0 is granted whenever it requests, and no other master is ever granted.
- R10: A table write takes effect at the next arbitration point. It does not disturb a grant that is being held.
- R11: If no master is requesting at an arbitration point, no grant is given in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table register write strobe |
| cfg_addr | input | 2 | Table register index (0 to 3) |
| cfg_wdata | input | 32 | Table register write data, four slot fields |
| req | input | 6 | Bus request, one bit per master |
| xfer_done | input | 6 | End-of-transfer strobe, one bit per master |
| grant | output | 6 | One-hot bus grant |
| grant_id | output | 3 | Index of the granted master, 0 when idle |

## Verification
A wrong slot pointer changes the order in which masters receive the bus. It therefore shows at the very next arbitration point, as the wrong grant_id one cycle after the release. A misread slot field shows the same way at the first grant that depends on that slot. This covers an enable bit taken from the wrong position, or a slot placed at the wrong byte of its register. A broken hold condition shows as a grant that changes while its master still requests without an end strobe. A wrong share shows only over a whole walk of the table, so the bench counts grants over full table periods.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;

  // Layout of one slot field; the search logic decodes it.
  localparam int SLOT_W  = 8;
  localparam int ID_W    = 3;
  localparam int EN_BIT  = 7;

  typedef logic [SLOT_W-1:0] slot_field_t;

  function automatic logic slot_live(input slot_field_t f);
    return f[EN_BIT];
  endfunction

  function automatic logic [ID_W-1:0] slot_owner(input slot_field_t f);
    return f[ID_W-1:0];
  endfunction

  // Slot index that follows s in a table of n slots.
  function automatic int unsigned slot_after(input int unsigned s, input int unsigned n);
    return (s + 1) % n;
  endfunction

endpackage

// File: rtl/slot_table.sv
module slot_table
  import slot_arb_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int REG_W     = 32,
  localparam int PER_REG  = REG_W / SLOT_W,
  localparam int NUM_REGS = NUM_SLOTS / PER_REG,
  localparam int REG_AW   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [REG_AW-1:0]       cfg_addr,
  input  logic [REG_W-1:0]        cfg_wdata,
  output slot_field_t [NUM_SLOTS-1:0] slots
);

  logic [NUM_REGS-1:0][REG_W-1:0] table_q;
  logic                           wr_hit;

  assign wr_hit = cfg_we && (int'(cfg_addr) < NUM_REGS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      table_q <= '0;
    end else if (wr_hit) begin
      table_q[cfg_addr] <= cfg_wdata;
    end
  end

  // Slot order: within a register the top byte comes first.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign slots[s] = table_q[s / PER_REG][REG_W-1-(s % PER_REG)*SLOT_W -: SLOT_W];
  end

  assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> table_q[$past(cfg_addr)] == $past(cfg_wdata));

endmodule

// File: rtl/slot_search.sv
module slot_search
  import slot_arb_pkg::*;
#(
  parameter int NUM_SLOTS   = 16,
  parameter int NUM_MASTERS = 6,
  localparam int PTR_W      = $clog2(NUM_SLOTS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  slot_field_t [NUM_SLOTS-1:0] slots,
  input  logic [NUM_MASTERS-1:0]      req,
  input  logic [PTR_W-1:0]            ptr,
  output logic                        hit,
  output logic [PTR_W-1:0]            hit_slot,
  output logic [ID_W-1:0]             hit_id,
  output logic                        any_live
);

  always_comb begin
    hit      = 1'b0;
    hit_slot = '0;
    hit_id   = '0;
    any_live = 1'b0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      logic [PTR_W-1:0] idx;
      logic [ID_W-1:0]  who;
      logic             wants;
      idx   = PTR_W'((int'(ptr) + k) % NUM_SLOTS);
      who   = slot_owner(slots[idx]);
      wants = (int'(who) < NUM_MASTERS) && req[who];
      if (slot_live(slots[idx])) any_live = 1'b1;
      if (!hit && slot_live(slots[idx]) && wants) begin
        hit      = 1'b1;
        hit_slot = idx;
        hit_id   = who;
      end
    end
  end

  assert_hit_is_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> slot_live(slots[hit_slot]));

  assert_hit_requests_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (int'(hit_id) < NUM_MASTERS) && req[hit_id]);

endmodule

// File: rtl/grant_ctrl.sv
module grant_ctrl
  import slot_arb_pkg::*;
#(
  parameter int NUM_SLOTS   = 16,
  parameter int NUM_MASTERS = 6,
  localparam int PTR_W      = $clog2(NUM_SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic [NUM_MASTERS-1:0] xfer_done,
  input  logic                   hit,
  input  logic [PTR_W-1:0]       hit_slot,
  input  logic [ID_W-1:0]        hit_id,
  input  logic                   any_live,
  output logic [PTR_W-1:0]       ptr,
  output logic [NUM_MASTERS-1:0] grant,
  output logic [ID_W-1:0]        grant_id
);

  logic            owner_v;
  logic [ID_W-1:0] owner_id;
  logic            hold_now;
  logic            fallback_now;

  assign hold_now     = owner_v && req[owner_id] && !xfer_done[owner_id];
  assign fallback_now = !hold_now && !any_live && req[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_v  <= 1'b0;
      owner_id <= '0;
      ptr      <= '0;
    end else if (!hold_now) begin
      if (hit) begin
        owner_v  <= 1'b1;
        owner_id <= hit_id;
        ptr      <= PTR_W'(slot_after(int'(hit_slot), NUM_SLOTS));
      end else if (fallback_now) begin
        owner_v  <= 1'b1;
        owner_id <= '0;
      end else begin
        owner_v  <= 1'b0;
        owner_id <= '0;
      end
    end
  end

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_grant
    assign grant[m] = owner_v && (int'(owner_id) == m);
  end
  assign grant_id = owner_id;

  assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_grant_requested_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~$past(req)) == '0);

  assert_hold_keeps_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_now |=> owner_v && owner_id == $past(owner_id));

  assert_fallback_cpu_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fallback_now |=> grant[0]);

  assert_idle_no_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_now && req == '0) |=> grant == '0);

endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
  import slot_arb_pkg::*;
#(
  parameter int NUM_SLOTS   = 16,
  parameter int NUM_MASTERS = 6,
  parameter int REG_W       = 32,
  localparam int PER_REG    = REG_W / SLOT_W,
  localparam int NUM_REGS   = NUM_SLOTS / PER_REG,
  localparam int REG_AW     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int PTR_W      = $clog2(NUM_SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [REG_AW-1:0]      cfg_addr,
  input  logic [REG_W-1:0]       cfg_wdata,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic [NUM_MASTERS-1:0] xfer_done,
  output logic [NUM_MASTERS-1:0] grant,
  output logic [ID_W-1:0]        grant_id
);

  slot_field_t [NUM_SLOTS-1:0] slots;
  logic [PTR_W-1:0]            ptr;
  logic                        hit;
  logic [PTR_W-1:0]            hit_slot;
  logic [ID_W-1:0]             hit_id;
  logic                        any_live;

  slot_table #(.NUM_SLOTS(NUM_SLOTS), .REG_W(REG_W)) table_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .slots(slots)
  );

  slot_search #(.NUM_SLOTS(NUM_SLOTS), .NUM_MASTERS(NUM_MASTERS)) search_i (
    .clk(clk), .rst_n(rst_n), .slots(slots), .req(req), .ptr(ptr),
    .hit(hit), .hit_slot(hit_slot), .hit_id(hit_id), .any_live(any_live)
  );

  grant_ctrl #(.NUM_SLOTS(NUM_SLOTS), .NUM_MASTERS(NUM_MASTERS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .req(req), .xfer_done(xfer_done),
    .hit(hit), .hit_slot(hit_slot), .hit_id(hit_id), .any_live(any_live),
    .ptr(ptr), .grant(grant), .grant_id(grant_id)
  );

  assert_id_matches_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grant != '0 |-> grant[grant_id]);

endmodule

// File: tb/slot_arbiter_tb_top.sv
module slot_arbiter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [1:0] cfg_addr;
  logic [31:0] cfg_wdata;
  logic [5:0] req;
  logic [5:0] xfer_done;
  logic [5:0] grant;
  logic [2:0] grant_id;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  slot_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req(req), .xfer_done(xfer_done),
    .grant(grant), .grant_id(grant_id)
  );

  function automatic logic [5:0] oh(input int m);
    return (m < 0) ? 6'b0 : 6'(1 << m);
  endfunction

  function automatic logic [7:0] live(input int m);
    return 8'h80 | 8'(m);
  endfunction

  task automatic check(input string tag, input int exp_m);
    checks++;
    if (grant !== oh(exp_m) || (exp_m >= 0 && grant_id !== 3'(exp_m))) begin
      fails++;
      $display("FAIL %s: grant=%b id=%0d expected grant=%b id=%0d",
               tag, grant, grant_id, oh(exp_m), exp_m);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req = '0; xfer_done = '0;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  task automatic step(input logic [5:0] r, input logic [5:0] d);
    req = r; xfer_done = d;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input int a, input logic [31:0] v);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = v;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req = 6'h3f; xfer_done = '0; cfg_we = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 grant low in reset", -1);
    rst_n = 1'b1; req = '0;
    @(posedge clk); #1;
    check("R1 no grant after reset", -1);
    step(6'b000010, 6'b0);
    check("R1 empty table ignores master 1", -1);
  endtask

  task automatic t_fallback();
    do_reset();
    step(6'b000011, 6'b0);
    check("R9 fallback grants master 0", 0);
    step(6'b000011, 6'b000001);
    check("R9 fallback regrants master 0", 0);
    step(6'b111110, 6'b0);
    check("R9 others never granted", -1);
  endtask

  task automatic t_order();
    do_reset();
    wr(0, {live(3), live(1), live(4), live(2)});
    begin
      int exp_seq [8] = '{3, 1, 4, 2, 3, 1, 4, 2};
      for (int i = 0; i < 8; i++) begin
        step(6'h3f, 6'h3f);
        check($sformatf("R3 slot order step %0d", i), exp_seq[i]);
      end
    end
  endtask

  task automatic t_skip();
    do_reset();
    wr(0, {live(3), live(1), live(4), live(2)});
    step(6'b000110, 6'h3f);
    check("R4 skip idle slot 0 in first cycle", 1);
    step(6'b000110, 6'h3f);
    check("R4 skip idle slot 2", 2);
    step(6'b000110, 6'h3f);
    check("R4 wrap skipping slots", 1);
  endtask

  task automatic t_disabled();
    do_reset();
    wr(0, {8'h05, live(1), 8'h00, 8'h00});
    step(6'b100000, 6'b0);
    check("R5 switched-off slot not granted", -1);
    step(6'b100001, 6'b0);
    check("R5 no fallback with live slots", -1);
    wr(0, {8'hFA, 8'h86, 8'h87, 8'h00});
    step(6'b000100, 6'b0);
    check("R2 bits 6:3 ignored", 2);
    step(6'b000000, 6'b0);
    step(6'b111011, 6'b0);
    check("R2 ids 6 and 7 never granted", -1);
  endtask

  task automatic t_hold();
    do_reset();
    wr(0, {live(1), live(2), 8'h00, 8'h00});
    step(6'b000110, 6'b0);
    check("R8 grant one cycle after request", 1);
    for (int i = 0; i < 3; i++) begin
      step(6'b000110, 6'b0);
      check("R7 grant held", 1);
    end
    step(6'b000110, 6'b000010);
    check("R7 release on xfer_done", 2);
    step(6'b000110, 6'b0);
    check("R7 new owner held", 2);
    step(6'b000010, 6'b0);
    check("R7 release on request drop", 1);
    step(6'b000000, 6'b0);
    check("R11 no requester no grant", -1);
  endtask

  task automatic t_share();
    do_reset();
    wr(0, {live(1), live(1), live(1), live(2)});
    begin
      int c1 = 0, c2 = 0;
      for (int i = 0; i < 16; i++) begin
        step(6'b000110, 6'h3f);
        if (grant == oh(1)) c1++;
        if (grant == oh(2)) c2++;
      end
      checks++;
      if (c1 != 12 || c2 != 4) begin
        fails++;
        $display("FAIL R6 share: m1=%0d m2=%0d expected 12 and 4", c1, c2);
      end
    end
    do_reset();
    wr(0, {live(0), live(1), live(0), live(2)});
    wr(1, {live(0), live(3), live(0), live(4)});
    wr(2, {live(0), live(5), 8'h00, 8'h00});
    begin
      int exp_seq [10] = '{0, 1, 0, 2, 0, 3, 0, 4, 0, 5};
      int cpu = 0;
      for (int i = 0; i < 20; i++) begin
        step(6'h3f, 6'h3f);
        check($sformatf("R6 cpu every other slot step %0d", i), exp_seq[i % 10]);
        if (grant == oh(0)) cpu++;
      end
      checks++;
      if (cpu != 10) begin
        fails++;
        $display("FAIL R6 cpu half: got %0d expected 10", cpu);
      end
    end
  endtask

  task automatic t_rewrite();
    do_reset();
    wr(0, {live(1), live(2), 8'h00, 8'h00});
    step(6'b001110, 6'b0);
    check("R10 initial owner", 1);
    req = 6'b001110;
    wr(0, {live(3), live(3), live(3), live(3)});
    check("R10 write keeps held grant", 1);
    step(6'b001110, 6'b000010);
    check("R10 new table at next arbitration", 3);
  endtask

  initial begin
    t_reset();
    t_fallback();
    t_order();
    t_skip();
    t_disabled();
    t_hold();
    t_share();
    t_rewrite();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule